// File: doc/BRIEF.md
# DMA Descriptor Address Generator

This block keeps the read (source) and write (destination) address of one DMA channel while the channel works through a chain of descriptors. When a descriptor is loaded it takes a 32-bit address field, an addressing mode and a 2-bit increment code for each side, and one shared unit data size. The unit size is a byte, a half-word or a word.

Each address field is taken either as an absolute address or as a signed-free offset added to the address the side already holds. The first descriptor of a chain is always treated as absolute. After loading, each side steps its address by a multiple of the unit size on every per-unit completion strobe for that side. The multiple is one, two or four units, or zero for a fixed target such as a FIFO.

The active mode and increment code of each side can be read back, so software can see what the last loaded linked descriptor asked for. Descriptor fetching, data movement and bus access are handled elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both addresses, both mode readbacks and both increment readbacks become zero, and so does the stored unit size.
- R2: A load with an effective mode of absolute (mode bit 0, or first descriptor) sets that side's address to the loaded field in the next cycle.
- R3: A load of a linked descriptor (`desc_first` low) with mode bit 1 sets that side's address to the previous address plus the loaded field, modulo 2^32.
- R4: A load with `desc_first` high uses absolute addressing on both sides whatever the mode bits are, and the mode readback of both sides shows 0 afterwards.
- R5: After a linked descriptor loads, each side's mode readback equals that descriptor's mode bit, and each side's increment readback equals its 2-bit increment code.
- R6: Unit size code 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes, and the reserved code 3 is treated as 4 bytes.
- R7: Increment codes 0, 1 and 2 advance an address by 1, 2 and 4 units respectively on each completion strobe of its side.
- R8: Increment code 3 leaves the address unchanged on completion strobes.
- R9: `rd_done` steps only the source address with the source code, and `wr_done` steps only the destination address with the destination code. Both may be high in the same cycle.
- R10: A load in the same cycle as a completion strobe wins: the address becomes the loaded value and is not also stepped in that cycle.
- R11: When neither a load nor a completion strobe is present, both addresses hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_load | input | 1 | Load strobe for a new descriptor |
| desc_first | input | 1 | Loaded descriptor is the first of a chain |
| src_field | input | 32 | Source address or offset |
| dst_field | input | 32 | Destination address or offset |
| src_rel | input | 1 | Source mode bit: 0 absolute, 1 relative |
| dst_rel | input | 1 | Destination mode bit: 0 absolute, 1 relative |
| src_inc | input | 2 | Source increment code |
| dst_inc | input | 2 | Destination increment code |
| unit_size | input | 2 | Unit data size code |
| rd_done | input | 1 | One unit has been read |
| wr_done | input | 1 | One unit has been written |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| src_rel_q | output | 1 | Source mode readback |
| dst_rel_q | output | 1 | Destination mode readback |
| src_inc_q | output | 2 | Source increment readback |
| dst_inc_q | output | 2 | Destination increment readback |

## Verification
A descriptor load and a per-unit completion strobe can arrive in the same cycle on either side, and the read and write strobes can also coincide with each other. The bench pulses `desc_load` together with both `rd_done` and `wr_done`. It then expects the freshly loaded absolute or relative address with no step applied, and checks that stepping resumes with the new code and size in the next cycle. Dual strobes without a load are swept over every size and increment combination, with each side's expected address accumulated arithmetically.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

    localparam int ADDR_W  = 32;
    localparam int SHAMT_W = 3;

    typedef enum logic [1:0] {
        INC_ONE  = 2'd0,
        INC_TWO  = 2'd1,
        INC_FOUR = 2'd2,
        INC_HOLD = 2'd3
    } inc_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic {
        AM_ABS = 1'b0,
        AM_REL = 1'b1
    } amode_e;

    typedef struct packed {
        amode_e              mode;
        inc_e                inc;
        logic [ADDR_W-1:0]   field;
    } side_desc_t;

    typedef struct packed {
        amode_e mode;
        inc_e   inc;
    } side_cfg_t;

    // log2 of the unit width in bytes; the reserved code maps to a word
    function automatic logic [SHAMT_W-1:0] unit_log2(input size_e sz);
        case (sz)
            SZ_BYTE: unit_log2 = SHAMT_W'(0);
            SZ_HALF: unit_log2 = SHAMT_W'(1);
            default: unit_log2 = SHAMT_W'(2);
        endcase
    endfunction

    // total shift = log2(unit) + log2(stride count)
    function automatic logic [SHAMT_W-1:0] step_shift(input size_e sz, input inc_e ic);
        logic [SHAMT_W-1:0] s;
        s = unit_log2(sz);
        case (ic)
            INC_TWO:  s = s + SHAMT_W'(1);
            INC_FOUR: s = s + SHAMT_W'(2);
            default:  s = s;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_step_calc.sv
module dma_step_calc
    import dma_addr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  size_e          size,
    input  inc_e           inc,
    output logic [AW-1:0]  step
);
    logic [SHAMT_W-1:0] shamt;

    always_comb begin
        shamt = step_shift(size, inc);
        if (inc == INC_HOLD) begin
            step = '0;
        end else begin
            step = AW'(1) << shamt;
        end
    end
endmodule

// File: rtl/dma_addr_side.sv
module dma_addr_side
    import dma_addr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            first,
    input  side_desc_t      desc,
    input  size_e           size_q,
    input  logic            done,
    output logic [AW-1:0]   addr,
    output side_cfg_t       cfg
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] step;
    amode_e        mode_eff;
    logic [AW-1:0] load_val;

    dma_step_calc #(.AW(AW)) u_step (
        .size (size_q),
        .inc  (cfg.inc),
        .step (step)
    );

    always_comb begin
        mode_eff = first ? AM_ABS : desc.mode;
        if (mode_eff == AM_REL) begin
            load_val = addr_q + desc.field[AW-1:0];
        end else begin
            load_val = desc.field[AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            cfg.mode <= AM_ABS;
            cfg.inc  <= INC_ONE;
        end else if (load) begin
            addr_q   <= load_val;
            cfg.mode <= mode_eff;
            cfg.inc  <= desc.inc;
        end else if (done) begin
            addr_q   <= addr_q + step;
        end
    end

    assign addr = addr_q;

    // R2
    abs_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && (first || desc.mode == AM_ABS)) |=> addr == $past(desc.field[AW-1:0]));

    // R4
    first_abs_chk: assert property (@(posedge clk) disable iff (rst)
        (load && first) |=> cfg.mode == AM_ABS);

    // R8
    hold_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && done && cfg.inc == INC_HOLD) |=> $stable(addr));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !done) |=> $stable(addr));

    // R7
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && done) |=> ((addr - $past(addr)) <= AW'(16)));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int SIDES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            desc_load,
    input  logic            desc_first,
    input  logic [AW-1:0]   src_field,
    input  logic [AW-1:0]   dst_field,
    input  logic            src_rel,
    input  logic            dst_rel,
    input  logic [1:0]      src_inc,
    input  logic [1:0]      dst_inc,
    input  logic [1:0]      unit_size,
    input  logic            rd_done,
    input  logic            wr_done,
    output logic [AW-1:0]   src_addr,
    output logic [AW-1:0]   dst_addr,
    output logic            src_rel_q,
    output logic            dst_rel_q,
    output logic [1:0]      src_inc_q,
    output logic [1:0]      dst_inc_q
);
    localparam int SRC = 0;
    localparam int DST = 1;

    size_e         size_q;
    side_desc_t    desc  [SIDES];
    logic          done  [SIDES];
    logic [AW-1:0] addr  [SIDES];
    side_cfg_t     cfg   [SIDES];

    always_comb begin
        desc[SRC].mode  = amode_e'(src_rel);
        desc[SRC].inc   = inc_e'(src_inc);
        desc[SRC].field = src_field;
        desc[DST].mode  = amode_e'(dst_rel);
        desc[DST].inc   = inc_e'(dst_inc);
        desc[DST].field = dst_field;
        done[SRC]       = rd_done;
        done[DST]       = wr_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= SZ_BYTE;
        end else if (desc_load) begin
            size_q <= size_e'(unit_size);
        end
    end

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dma_addr_side #(.AW(AW)) u_side (
            .clk    (clk),
            .rst    (rst),
            .load   (desc_load),
            .first  (desc_first),
            .desc   (desc[g]),
            .size_q (size_q),
            .done   (done[g]),
            .addr   (addr[g]),
            .cfg    (cfg[g])
        );
    end

    assign src_addr  = addr[SRC];
    assign dst_addr  = addr[DST];
    assign src_rel_q = cfg[SRC].mode;
    assign dst_rel_q = cfg[DST].mode;
    assign src_inc_q = cfg[SRC].inc;
    assign dst_inc_q = cfg[DST].inc;

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_load && !desc_first && !src_rel && rd_done) |=> src_addr == $past(src_field));
endmodule

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        desc_load, desc_first;
    logic [31:0] src_field, dst_field;
    logic        src_rel, dst_rel;
    logic [1:0]  src_inc, dst_inc, unit_size;
    logic        rd_done, wr_done;
    logic [31:0] src_addr, dst_addr;
    logic        src_rel_q, dst_rel_q;
    logic [1:0]  src_inc_q, dst_inc_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] es, ed;
    logic [1:0]  cur_sz, cur_si, cur_di;

    always #2.5 clk = ~clk;

    dma_addr_gen u0 (
        .clk(clk), .rst(rst), .desc_load(desc_load), .desc_first(desc_first),
        .src_field(src_field), .dst_field(dst_field), .src_rel(src_rel), .dst_rel(dst_rel),
        .src_inc(src_inc), .dst_inc(dst_inc), .unit_size(unit_size),
        .rd_done(rd_done), .wr_done(wr_done), .src_addr(src_addr), .dst_addr(dst_addr),
        .src_rel_q(src_rel_q), .dst_rel_q(dst_rel_q), .src_inc_q(src_inc_q), .dst_inc_q(dst_inc_q)
    );

    function automatic logic [31:0] exp_step(input logic [1:0] sz, input logic [1:0] ic);
        int unit, cnt;
        unit = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        cnt  = (ic == 2'd3) ? 0 : (ic == 2'd0) ? 1 : (ic == 2'd1) ? 2 : 4;
        return 32'(unit * cnt);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        desc_load = 0; desc_first = 0; src_field = '0; dst_field = '0;
        src_rel = 0; dst_rel = 0; src_inc = 0; dst_inc = 0; unit_size = 0;
        rd_done = 0; wr_done = 0;
    endtask

    // one cycle: inputs set after a falling edge, outputs checked at the next falling edge
    task automatic do_load(input logic first, input logic [31:0] sf, input logic [31:0] df,
                           input logic sr, input logic dr, input logic [1:0] si,
                           input logic [1:0] di, input logic [1:0] sz,
                           input logic rd, input logic wr);
        desc_load = 1; desc_first = first; src_field = sf; dst_field = df;
        src_rel = sr; dst_rel = dr; src_inc = si; dst_inc = di; unit_size = sz;
        rd_done = rd; wr_done = wr;
        es = (!first && sr) ? es + sf : sf;
        ed = (!first && dr) ? ed + df : df;
        cur_sz = sz; cur_si = si; cur_di = di;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_done(input logic rd, input logic wr);
        rd_done = rd; wr_done = wr;
        if (rd) es = es + exp_step(cur_sz, cur_si);
        if (wr) ed = ed + exp_step(cur_sz, cur_di);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(5ns * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  %0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
        $finish;
    end

    initial begin
        idle_inputs();
        es = '0; ed = '0; cur_sz = 0; cur_si = 0; cur_di = 0;
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 src_addr", src_addr, 32'h0);
        chk("R1 dst_addr", dst_addr, 32'h0);
        chk("R1 modes", {30'h0, src_rel_q, dst_rel_q}, 32'h0);
        chk("R1 incs", {28'h0, src_inc_q, dst_inc_q}, 32'h0);
        // R11 idle hold
        @(negedge clk); @(negedge clk);
        chk("R11 src idle", src_addr, 32'h0);

        // sweep size x source code x destination code
        for (int sz = 0; sz < 4; sz++) begin
            for (int si = 0; si < 4; si++) begin
                for (int di = 0; di < 4; di++) begin
                    // R4 first descriptor with mode bits set is still absolute
                    do_load(1'b1, 32'h1000_0000 + 32'(sz*256 + si*16 + di),
                            32'h2000_0000 + 32'(di*64 + si),
                            1'b1, 1'b1, 2'(si), 2'(di), 2'(sz), 1'b0, 1'b0);
                    chk("R4 R2 src load", src_addr, es);
                    chk("R4 R2 dst load", dst_addr, ed);
                    chk("R4 modes", {30'h0, src_rel_q, dst_rel_q}, 32'h0);
                    // R5 increment readback
                    chk("R5 incs", {28'h0, src_inc_q, dst_inc_q}, {28'h0, 2'(si), 2'(di)});
                    // R6 R7 R8 R9 stepping
                    do_done(1'b1, 1'b0);
                    chk("R9 R6 R7 R8 src step", src_addr, es);
                    chk("R9 dst untouched by rd", dst_addr, ed);
                    do_done(1'b0, 1'b1);
                    chk("R9 src untouched by wr", src_addr, es);
                    chk("R6 R7 R8 dst step", dst_addr, ed);
                    do_done(1'b1, 1'b1);
                    chk("R9 dual src", src_addr, es);
                    chk("R9 dual dst", dst_addr, ed);
                    // R11 idle cycle
                    @(negedge clk);
                    chk("R11 src hold", src_addr, es);
                    chk("R11 dst hold", dst_addr, ed);
                end
            end
        end

        // R3 relative linked load with wraparound, R5 mode readback
        do_load(1'b1, 32'hFFFF_FFF0, 32'h0000_0100, 1'b0, 1'b0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0);
        do_load(1'b0, 32'h0000_0020, 32'h0000_0040, 1'b1, 1'b1, 2'd2, 2'd3, 2'd1, 1'b0, 1'b0);
        chk("R3 src wrap", src_addr, 32'h0000_0010);
        chk("R3 dst rel", dst_addr, 32'h0000_0140);
        chk("R5 modes linked", {30'h0, src_rel_q, dst_rel_q}, 32'h3);
        chk("R5 incs linked", {28'h0, src_inc_q, dst_inc_q}, {28'h0, 2'd2, 2'd3});
        // mixed modes on a linked descriptor
        do_load(1'b0, 32'h0000_0004, 32'hABCD_0000, 1'b1, 1'b0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0);
        chk("R3 src mixed", src_addr, 32'h0000_0014);
        chk("R2 dst mixed", dst_addr, 32'hABCD_0000);
        chk("R5 modes mixed", {30'h0, src_rel_q, dst_rel_q}, 32'h2);

        // R10 load with both strobes in the same cycle: no step
        do_load(1'b0, 32'h0000_0100, 32'h0000_0008, 1'b0, 1'b1, 2'd0, 2'd2, 2'd2, 1'b1, 1'b1);
        chk("R10 src load wins", src_addr, 32'h0000_0100);
        chk("R10 dst load wins", dst_addr, 32'hABCD_0008);
        do_done(1'b1, 1'b1);
        chk("R10 src steps after", src_addr, 32'h0000_0104);
        chk("R10 dst steps after", dst_addr, 32'hABCD_0018);

        // R1 reset again mid-run
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R1 src after reset", src_addr, 32'h0);
        chk("R1 dst after reset", dst_addr, 32'h0);
        chk("R1 readback after reset", {28'h0, src_rel_q, dst_rel_q, src_inc_q ^ dst_inc_q}, 32'h0);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule